// File: doc/BRIEF.md
# Bitwise Execution Unit with Condition Flags

This block is the logical-operation slice of a 64-bit integer execution pipeline. Each cycle it may accept one operation, marked by an input strobe. An operation carries two source operands, a 16-bit unsigned immediate, a 5-bit operation code, a record bit and the current sticky summary-overflow bit. One clock later the block presents a 64-bit result, a 4-bit condition field and a write enable for that field, all marked by an output valid pulse.

The operations fall into four groups:

- **Immediate forms.** AND, OR and XOR against the zero-extended immediate, placed either in the low 16 bits or moved up into bits 31:16.
- **Two-register logic.** AND, OR, XOR, NAND, NOR, XNOR, AND-with-complement and OR-with-complement.
- **Sign extension.** Extends the low byte, halfword or word of the first operand.
- **Reserved codes.** All other codes give a result of zero.

Only some operations produce condition flags. The AND immediate forms always produce them. The OR and XOR immediate forms never do. The register and sign-extend groups produce them only when the record bit is set. The block has no carry or overflow state of its own. It never drives such state, and the summary-overflow bit only passes through into the condition field.

Top module: `bitwise_exec_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `cond_we`, `result` and `cond` are all zero until the first strobe.
- R2: An operation strobed with `in_valid` at a clock edge appears on `result`, `cond` and `cond_we` after that edge, with `out_valid` high for exactly that one cycle. Without a strobe, `out_valid` is low, `cond_we` is low and `result` holds its last value.
- R3: Codes 0, 1 and 2 give `src_a & Z`, `src_a | Z` and `src_a ^ Z`, where Z is `imm16` zero-extended to 64 bits. `src_b` has no effect on these codes.
- R4: Codes 3, 4 and 5 give AND, OR and XOR of `src_a` with `imm16` placed in bits 31:16, with zeros in bits 15:0 and in bits 63:32.
- R5: Codes 0 and 3 (AND immediate) always raise `cond_we`. Codes 1, 2, 4 and 5 never raise it. `rec_bit` has no effect on any immediate code.
- R6: Codes 6, 7 and 8 give `src_a & src_b`, `src_a | src_b` and `src_a ^ src_b`.
- R7: Codes 9 to 13 give NAND, NOR, XNOR (complement of XOR), `src_a & ~src_b` and `src_a | ~src_b`, in that order.
- R8: Codes 14, 15 and 16 copy bit 7, bit 15 or bit 31 of `src_a` into every higher result bit and keep the bits below it.
- R9: Codes 6 to 16 raise `cond_we` exactly when `rec_bit` was 1 with the strobe.
- R10: When `cond_we` is high, `cond[3]`=LT, `cond[2]`=GT and `cond[1]`=EQ, from a signed comparison of the result with zero, and exactly one of the three is set. `cond[0]` is the `so_in` value sampled with the strobe.
- R11: `cond` is 4'b0000 whenever `cond_we` is low.
- R12: Codes 17 to 31 are reserved. They give a result of zero, and `cond_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 5 | Operation code |
| rec_bit | input | 1 | Record request for register and sign-extend codes |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| imm16 | input | 16 | Unsigned immediate |
| so_in | input | 1 | Sticky summary-overflow bit, passed through |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Operation result |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |
| cond_we | output | 1 | Condition field write enable |

## Verification
The assertions check, on every cycle, the properties that hold for any operand:

- the one-cycle latency of the valid pulse, and that the result holds without a strobe;
- which code groups may or must raise the flag write enable;
- that LT, GT and EQ are one-hot and agree with the sign and zero-ness of the result;
- that SO passes through, and that the condition field is clear when not written.

The actual data values can only be shown by the bench's scenarios. These cover each logic function, the position of the shifted immediate, the sign extension around bits 7, 15 and 31, and the zero result of reserved codes. They are checked against a reference model on all-zeros, all-ones, sign-boundary and random operands.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int unsigned LU_XLEN  = 64;
    localparam int unsigned LU_IMM_W = 16;
    localparam int unsigned LU_OP_W  = 5;
    localparam int unsigned LU_CC_W  = 4;

    typedef enum logic [LU_OP_W-1:0] {
        OP_ANDI    = 5'd0,
        OP_ORI     = 5'd1,
        OP_XORI    = 5'd2,
        OP_ANDI_HI = 5'd3,
        OP_ORI_HI  = 5'd4,
        OP_XORI_HI = 5'd5,
        OP_AND     = 5'd6,
        OP_OR      = 5'd7,
        OP_XOR     = 5'd8,
        OP_NAND    = 5'd9,
        OP_NOR     = 5'd10,
        OP_XNOR    = 5'd11,
        OP_ANDC    = 5'd12,
        OP_ORC     = 5'd13,
        OP_SX_B    = 5'd14,
        OP_SX_H    = 5'd15,
        OP_SX_W    = 5'd16
    } lu_op_e;

    localparam logic [LU_OP_W-1:0] OP_LAST_VALID = 5'd16;

    // Condition field layout: bit 3 LT, bit 2 GT, bit 1 EQ, bit 0 SO
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } lu_cc_t;

    // Operation group used by operand selection and flag policy
    typedef enum logic [1:0] {
        GRP_IMM_AND = 2'd0,
        GRP_IMM_NOF = 2'd1,
        GRP_REC     = 2'd2,
        GRP_RSVD    = 2'd3
    } lu_grp_e;

    function automatic lu_grp_e lu_group(input logic [LU_OP_W-1:0] op);
        lu_grp_e g;
        if (op == OP_ANDI || op == OP_ANDI_HI) begin
            g = GRP_IMM_AND;
        end else if (op == OP_ORI || op == OP_XORI || op == OP_ORI_HI || op == OP_XORI_HI) begin
            g = GRP_IMM_NOF;
        end else if (op <= OP_LAST_VALID) begin
            g = GRP_REC;
        end else begin
            g = GRP_RSVD;
        end
        return g;
    endfunction

endpackage

// File: rtl/lu_operand_mux.sv
module lu_operand_mux
    import lu_pkg::*;
#(
    parameter int unsigned XLEN  = LU_XLEN,
    parameter int unsigned IMM_W = LU_IMM_W,
    parameter int unsigned OP_W  = LU_OP_W
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [XLEN-1:0]  src_b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  opnd_b
);
    localparam int unsigned LO_PAD = XLEN - IMM_W;
    localparam int unsigned HI_PAD = XLEN - 2*IMM_W;

    logic [XLEN-1:0] imm_lo;
    logic [XLEN-1:0] imm_hi;

    assign imm_lo = {{LO_PAD{1'b0}}, imm};
    assign imm_hi = {{HI_PAD{1'b0}}, imm, {IMM_W{1'b0}}};

    always_comb begin
        case (op_sel)
            OP_ANDI, OP_ORI, OP_XORI:          opnd_b = imm_lo;
            OP_ANDI_HI, OP_ORI_HI, OP_XORI_HI: opnd_b = imm_hi;
            default:                           opnd_b = src_b;
        endcase
    end
endmodule

// File: rtl/lu_logic_core.sv
module lu_logic_core
    import lu_pkg::*;
#(
    parameter int unsigned XLEN  = LU_XLEN,
    parameter int unsigned OP_W  = LU_OP_W,
    parameter int unsigned SX_W0 = 8,
    parameter int unsigned SX_W1 = 16,
    parameter int unsigned SX_W2 = 32
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] res
);
    localparam int unsigned N_SX = 3;

    logic [XLEN-1:0] sx_val [N_SX];

    for (genvar g = 0; g < N_SX; g++) begin : g_sx
        localparam int unsigned W = (g == 0) ? SX_W0 : ((g == 1) ? SX_W1 : SX_W2);
        assign sx_val[g] = {{(XLEN-W){opnd_a[W-1]}}, opnd_a[W-1:0]};
    end

    logic [XLEN-1:0] and_v, or_v, xor_v;
    assign and_v = opnd_a & opnd_b;
    assign or_v  = opnd_a | opnd_b;
    assign xor_v = opnd_a ^ opnd_b;

    always_comb begin
        case (op_sel)
            OP_ANDI, OP_ANDI_HI, OP_AND: res = and_v;
            OP_ORI, OP_ORI_HI, OP_OR:    res = or_v;
            OP_XORI, OP_XORI_HI, OP_XOR: res = xor_v;
            OP_NAND:                     res = ~and_v;
            OP_NOR:                      res = ~or_v;
            OP_XNOR:                     res = ~xor_v;
            OP_ANDC:                     res = opnd_a & ~opnd_b;
            OP_ORC:                      res = opnd_a | ~opnd_b;
            OP_SX_B:                     res = sx_val[0];
            OP_SX_H:                     res = sx_val[1];
            OP_SX_W:                     res = sx_val[2];
            default:                     res = '0;
        endcase
    end
endmodule

// File: rtl/lu_flag_gen.sv
module lu_flag_gen
    import lu_pkg::*;
#(
    parameter int unsigned XLEN = LU_XLEN,
    parameter int unsigned OP_W = LU_OP_W
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic            rec_bit,
    input  logic            so_in,
    input  logic [XLEN-1:0] res,
    output lu_cc_t          cc,
    output logic            cc_we
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = res[XLEN-1];
    assign is_zero = ~|res;

    always_comb begin
        cc.lt = is_neg;
        cc.gt = ~is_neg & ~is_zero;
        cc.eq = is_zero;
        cc.so = so_in;
        case (lu_group(op_sel))
            GRP_IMM_AND: cc_we = 1'b1;
            GRP_REC:     cc_we = rec_bit;
            default:     cc_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitwise_exec_unit.sv
module bitwise_exec_unit
    import lu_pkg::*;
#(
    parameter int unsigned XLEN  = LU_XLEN,
    parameter int unsigned IMM_W = LU_IMM_W,
    parameter int unsigned OP_W  = LU_OP_W,
    parameter int unsigned CC_W  = LU_CC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_sel,
    input  logic             rec_bit,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [IMM_W-1:0] imm16,
    input  logic             so_in,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic [CC_W-1:0]  cond,
    output logic             cond_we
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic [CC_W-1:0] cc;
        logic            we;
    } stage_t;

    stage_t st_d, st_q;

    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] core_res;
    lu_cc_t          fl_cc;
    logic            fl_we;

    lu_operand_mux #(.XLEN(XLEN), .IMM_W(IMM_W), .OP_W(OP_W)) u_opnd (
        .op_sel (op_sel),
        .src_b  (src_b),
        .imm    (imm16),
        .opnd_b (opnd_b)
    );

    lu_logic_core #(.XLEN(XLEN), .OP_W(OP_W)) u_core (
        .op_sel (op_sel),
        .opnd_a (src_a),
        .opnd_b (opnd_b),
        .res    (core_res)
    );

    lu_flag_gen #(.XLEN(XLEN), .OP_W(OP_W)) u_flags (
        .op_sel  (op_sel),
        .rec_bit (rec_bit),
        .so_in   (so_in),
        .res     (core_res),
        .cc      (fl_cc),
        .cc_we   (fl_we)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.we  = 1'b0;
        st_d.cc  = '0;
        if (in_valid) begin
            st_d.res = core_res;
            st_d.we  = fl_we;
            st_d.cc  = fl_we ? CC_W'(fl_cc) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cond      = st_q.cc;
    assign cond_we   = st_q.we;
endmodule

// File: rtl/lu_checker.sv
module lu_checker
    import lu_pkg::*;
#(
    parameter int unsigned XLEN = LU_XLEN,
    parameter int unsigned OP_W = LU_OP_W,
    parameter int unsigned CC_W = LU_CC_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] op_sel,
    input logic            rec_bit,
    input logic            so_in,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic [CC_W-1:0] cond,
    input logic            cond_we
);
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !cond_we && $stable(result)));
    p_andimm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == OP_ANDI || op_sel == OP_ANDI_HI)) |=> cond_we);
    p_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == OP_ORI || op_sel == OP_XORI ||
                      op_sel == OP_ORI_HI || op_sel == OP_XORI_HI)) |=> !cond_we);
    p_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= OP_AND && op_sel <= OP_SX_W) |=> (cond_we == $past(rec_bit)));
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> ($countones(cond[3:1]) == 1));
    p_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> (cond[1] == (result == '0)));
    p_lt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> (cond[3] == result[XLEN-1]));
    p_so_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!cond_we || cond[0] == $past(so_in)));
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_we |-> (cond == '0));
    p_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel > OP_LAST_VALID) |=> (!cond_we && result == '0));
    p_we_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> out_valid);
endmodule

bind bitwise_exec_unit lu_checker #(.XLEN(XLEN), .OP_W(OP_W), .CC_W(CC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .rec_bit   (rec_bit),
    .so_in     (so_in),
    .out_valid (out_valid),
    .result    (result),
    .cond      (cond),
    .cond_we   (cond_we)
);

// File: tb/sim_bitwise_exec_unit.sv
`timescale 1ns/1ps
module sim_bitwise_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic        rec_bit = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic        so_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic [3:0]  cond;
    logic        cond_we;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bitwise_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .rec_bit(rec_bit), .src_a(src_a), .src_b(src_b), .imm16(imm16),
        .so_in(so_in), .out_valid(out_valid), .result(result),
        .cond(cond), .cond_we(cond_we)
    );

    function automatic logic [63:0] ref_res(input logic [4:0] op, input logic [63:0] a,
                                            input logic [63:0] b, input logic [15:0] im);
        logic [63:0] zl, zh;
        zl = 64'(im);
        zh = 64'(im) << 16;
        case (op)
            5'd0:  return a & zl;
            5'd1:  return a | zl;
            5'd2:  return a ^ zl;
            5'd3:  return a & zh;
            5'd4:  return a | zh;
            5'd5:  return a ^ zh;
            5'd6:  return a & b;
            5'd7:  return a | b;
            5'd8:  return a ^ b;
            5'd9:  return ~(a & b);
            5'd10: return ~(a | b);
            5'd11: return ~(a ^ b);
            5'd12: return a & ~b;
            5'd13: return a | ~b;
            5'd14: return 64'($signed(a[7:0]));
            5'd15: return 64'($signed(a[15:0]));
            5'd16: return 64'($signed(a[31:0]));
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic ref_we(input logic [4:0] op, input logic rec);
        if (op == 5'd0 || op == 5'd3) return 1'b1;
        if (op <= 5'd5) return 1'b0;
        if (op <= 5'd16) return rec;
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Strobe one operation and check every output one cycle later
    task automatic run_op(input string req, input logic [4:0] op, input logic [63:0] a,
                          input logic [63:0] b, input logic [15:0] im,
                          input logic rec, input logic so);
        logic [63:0] er;
        logic        ew;
        logic [3:0]  ec;
        er = ref_res(op, a, b, im);
        ew = ref_we(op, rec);
        ec = ew ? {er[63], !er[63] && er != 0, er == 0, so} : 4'b0000;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; imm16 = im; rec_bit = rec; so_in = so;
        in_valid = 1'b1;
        @(negedge clk);
        check(req, "out_valid", 64'(out_valid), 64'd1);
        check(req, "result", result, er);
        check(req, "cond_we", 64'(cond_we), 64'(ew));
        check(req, "cond", 64'(cond), 64'(ec));
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "cond_we", 64'(cond_we), 64'd0);
        check("R1", "result", result, 64'd0);
        check("R1", "cond", 64'(cond), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "result after release", result, 64'd0);
        check("R1", "out_valid after release", 64'(out_valid), 64'd0);
    endtask

    task automatic t_imm;
        run_op("R3", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 16'h8F0F, 1'b0, 1'b0);
        run_op("R3", 5'd1, 64'h8000_0000_0000_0000, 64'hFFFF, 16'hA5A5, 1'b1, 1'b0);
        run_op("R3", 5'd2, 64'h0123_4567_89AB_CDEF, 64'h0, 16'hFFFF, 1'b1, 1'b1);
        run_op("R5", 5'd0, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF, 16'hFFFF, 1'b0, 1'b1);
        run_op("R5", 5'd2, 64'h0, 64'h0, 16'h0, 1'b1, 1'b1);
    endtask

    task automatic t_shifted;
        run_op("R4", 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'hC003, 1'b0, 1'b1);
        run_op("R4", 5'd4, 64'h0, 64'hFFFF_FFFF, 16'h8001, 1'b1, 1'b0);
        run_op("R4", 5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'hFFFF, 1'b0, 1'b0);
        run_op("R5", 5'd3, 64'h0000_0000_0000_FFFF, 64'h0, 16'hFFFF, 1'b0, 1'b0);
    endtask

    task automatic t_regreg;
        for (int op = 6; op <= 13; op++) begin
            run_op(op <= 8 ? "R6" : "R7", 5'(op), 64'hF0F0_FF00_0000_FFFF,
                   64'hFF00_F0F0_FFFF_0000, 16'h1111, 1'b1, 1'b0);
            run_op(op <= 8 ? "R6" : "R7", 5'(op), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                   16'h0, 1'b0, 1'b1);
        end
    endtask

    task automatic t_sext;
        run_op("R8", 5'd14, 64'h1234_5678_9ABC_DE80, 64'h0, 16'h0, 1'b1, 1'b0);
        run_op("R8", 5'd14, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0, 16'h0, 1'b1, 1'b0);
        run_op("R8", 5'd15, 64'h0000_0000_0000_8000, 64'h0, 16'h0, 1'b1, 1'b1);
        run_op("R8", 5'd15, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0, 16'h0, 1'b0, 1'b0);
        run_op("R8", 5'd16, 64'h0000_0000_8000_0000, 64'h0, 16'h0, 1'b1, 1'b0);
        run_op("R8", 5'd16, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 16'h0, 1'b1, 1'b0);
        run_op("R8", 5'd16, 64'hABCD_0000_0000_0000, 64'h0, 16'h0, 1'b1, 1'b1);
    endtask

    task automatic t_record;
        run_op("R9", 5'd8, 64'h5, 64'h5, 16'h0, 1'b0, 1'b1);
        run_op("R9", 5'd8, 64'h5, 64'h5, 16'h0, 1'b1, 1'b1);
        run_op("R10", 5'd7, 64'h8000_0000_0000_0000, 64'h0, 16'h0, 1'b1, 1'b0);
        run_op("R10", 5'd7, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 1'b1, 1'b1);
        run_op("R11", 5'd6, 64'hFFFF, 64'hFFFF, 16'h0, 1'b0, 1'b1);
    endtask

    task automatic t_reserved;
        run_op("R12", 5'd17, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1'b1, 1'b1);
        run_op("R12", 5'd31, 64'h1, 64'h1, 16'h1, 1'b1, 1'b0);
    endtask

    task automatic t_hold;
        logic [63:0] keep;
        run_op("R2", 5'd7, 64'hDEAD_BEEF_0000_0001, 64'h0, 16'h0, 1'b1, 1'b0);
        keep = 64'hDEAD_BEEF_0000_0001;
        @(negedge clk);
        op_sel = 5'd6; src_a = 64'h0; src_b = 64'h0; rec_bit = 1'b1;
        @(negedge clk);
        check("R2", "idle out_valid", 64'(out_valid), 64'd0);
        check("R2", "idle result hold", result, keep);
        check("R2", "idle cond_we", 64'(cond_we), 64'd0);
        check("R11", "idle cond", 64'(cond), 64'd0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [4:0] op;
            op = 5'($urandom_range(0, 16));
            run_op("R6", op, {$urandom, $urandom}, {$urandom, $urandom},
                   16'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        t_reset;
        t_imm;
        t_shifted;
        t_regreg;
        t_sext;
        t_record;
        t_reserved;
        t_hold;
        t_random;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule